// File: doc/BRIEF.md
# Grouped External Interrupt Controller

This block collects 28 external interrupt lines, synchronises each one to the system clock, and turns activity on each line into a sticky pending flag according to a per-pair trigger setting. Software sets the trigger kind (low level, high level, rising edge, falling edge or both edges), masks or enables each line, and clears the flags it has serviced by writing ones to the pending word.

Flags that are pending and not masked are folded into four request outputs of unequal size. These outputs feed a downstream vectored interrupt controller. Software then reads the pending word, ANDs it with the inverted mask, and services the lines it finds. A pending flag is recorded even while its line is masked.

The register bus is a single-cycle strobe interface with four word addresses: two trigger configuration words, the mask word and the pending word. Reads return data in the same cycle as the strobe.

Top module: `ext_irq_grouper`

## Requirements
- R1: While reset is active and after reset, the mask word reads 0x0FFFFFFF, the pending word reads 0, both configuration words read 0, and every request output is 0.
- R2: Address 0 holds the trigger fields for lines 0 to 15 and address 1 holds the fields for lines 16 to 27. The 3-bit field for a line starts at bit ((line mod 16)/2)*4. Bit 3 of each nibble reads 0. Bits 31:24 of address 1 read 0, and writes to them have no effect.
- R3: Field value 000 sets the pending flag on every cycle the synchronised line is low, and 001 does the same while it is high. A clear written while the level is still active leaves the flag set. Once the line is inactive, a clear removes the flag.
- R4: Field values 100 and 101 set the flag on a 0-to-1 transition of the line only.
- R5: Field values 010 and 011 set the flag on a 1-to-0 transition of the line only.
- R6: Field values 110 and 111 set the flag on either transition.
- R7: The mask word (address 2, bit n = line n, 1 = blocked) changes only when it is written. A flag still becomes pending while its line is masked, and that masked flag drives no request output.
- R8: Writing the pending word (address 3) clears each flag whose data bit is 1. Flags whose data bit is 0 are unchanged.
- R9: When a trigger event and a clear of the same flag fall in the same cycle, the flag ends up set.
- R10: Request output 0 is the OR of unmasked pending flags 0 to 3. Output 1 covers lines 4 to 11, output 2 covers lines 12 to 19, and output 3 covers lines 20 to 27.
- R11: A change on a line input shows up in the pending word and the request outputs on the third rising clock edge after the change, and not before it. A pending flag never rises without a detected event.
- R12: Bits 31:28 of the mask and pending words read 0, and writes to them have no effect.
- R13: The two lines 2k and 2k+1 share one trigger field, so configuring the field through either line governs both.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| pin_i | input | 28 | Asynchronous external interrupt lines |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address: 0/1 config, 2 mask, 3 pending |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| grp_req_o | output | 4 | Request outputs for line groups 0-3, 4-11, 12-19, 20-27 |

## Verification
A line change passes two synchroniser flops and then the edge/level detector, so its flag appears on the third rising edge. The bench drives a line just after a falling edge and samples the pending word once after two rising edges, where it must still be clear. It samples again after the third rising edge, where the flag and the group output must be valid. Register writes take effect at the edge inside the write strobe, and reads are combinational, so each check after a write samples at the following falling edge. The set-beats-clear case is built by timing the clear strobe to land on exactly that third edge.

// File: rtl/xirq_pkg.sv
package xirq_pkg;

  localparam int PIN_N         = 28;
  localparam int GRP_N         = 4;
  localparam int DAT_W         = 32;
  localparam int ADR_W         = 2;
  localparam int FLD_W         = 3;
  localparam int NIB_W         = 4;
  localparam int FLD_PER_WORD  = DAT_W / NIB_W;
  localparam int PINS_PER_WORD = FLD_PER_WORD * 2;
  localparam int FLD_N         = (PIN_N + 1) / 2;
  localparam int CFG_WORDS     = (PIN_N + PINS_PER_WORD - 1) / PINS_PER_WORD;
  localparam int GRP0_PINS     = 4;
  localparam int GRPX_PINS     = 8;

  typedef enum logic [ADR_W-1:0] {
    RA_CFG0 = 2'd0,
    RA_CFG1 = 2'd1,
    RA_MASK = 2'd2,
    RA_PEND = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    TK_LEVEL = 2'b00,
    TK_FALL  = 2'b01,
    TK_RISE  = 2'b10,
    TK_BOTH  = 2'b11
  } trig_kind_e;

  function automatic int grp_first(input int g);
    return (g == 0) ? 0 : GRP0_PINS + (g - 1) * GRPX_PINS;
  endfunction

  function automatic int grp_last(input int g);
    return (g == 0) ? GRP0_PINS - 1 : grp_first(g) + GRPX_PINS - 1;
  endfunction

endpackage

// File: rtl/xirq_rst_sync.sv
module xirq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_o
);

  logic [1:0] rs_q;
  logic [1:0] rs_d;

  always_comb begin
    rs_d = {rs_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs_q <= 2'b00;
    end else begin
      rs_q <= rs_d;
    end
  end

  assign rst_n_o = rs_q[1];

endmodule

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int W      = 28,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);

  logic [STAGES-1:0][W-1:0] stg_q;
  logic [STAGES-1:0][W-1:0] stg_d;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      assign stg_d[s] = d_i;
    end else begin : g_next
      assign stg_d[s] = stg_q[s-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stg_q[s] <= '0;
      end else begin
        stg_q[s] <= stg_d[s];
      end
    end
  end

  assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/xirq_detect.sv
module xirq_detect
  import xirq_pkg::*;
#(
  parameter int W = PIN_N
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [W-1:0]           lvl_i,
  input  logic [W-1:0][FLD_W-1:0] mode_i,
  output logic [W-1:0]           evt_o
);

  logic [W-1:0] prev_q;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
    end else begin
      prev_q <= lvl_i;
    end
  end

  assign rise = lvl_i & ~prev_q;
  assign fall = ~lvl_i & prev_q;

  for (genvar p = 0; p < W; p++) begin : g_pin
    trig_kind_e kind;
    logic       evt_b;

    assign kind = trig_kind_e'(mode_i[p][FLD_W-1:1]);

    always_comb begin
      unique case (kind)
        TK_LEVEL: evt_b = mode_i[p][0] ? lvl_i[p] : ~lvl_i[p];
        TK_FALL:  evt_b = fall[p];
        TK_RISE:  evt_b = rise[p];
        default:  evt_b = rise[p] | fall[p];
      endcase
    end

    assign evt_o[p] = evt_b;
  end

endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
(
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       bus_sel,
  input  logic                       bus_wr,
  input  logic [ADR_W-1:0]           bus_addr,
  input  logic [DAT_W-1:0]           bus_wdata,
  output logic [DAT_W-1:0]           bus_rdata,
  input  logic [PIN_N-1:0]           evt_i,
  output logic [PIN_N-1:0]           mask_o,
  output logic [PIN_N-1:0]           pend_o,
  output logic [PIN_N-1:0][FLD_W-1:0] mode_o
);

  localparam int PAD_W = DAT_W - PIN_N;

  logic                        wr_act;
  logic [FLD_N-1:0][FLD_W-1:0] fld_q;
  logic [FLD_N-1:0][FLD_W-1:0] fld_d;
  logic [FLD_N-1:0]            fld_en;
  logic [PIN_N-1:0]            mask_q;
  logic [PIN_N-1:0]            mask_d;
  logic                        mask_en;
  logic [PIN_N-1:0]            pend_q;
  logic [PIN_N-1:0]            pend_d;
  logic [PIN_N-1:0]            clr_vec;
  logic [CFG_WORDS-1:0][DAT_W-1:0] cfg_rd;
  logic                        wdata_unused;

  assign wr_act       = bus_sel & bus_wr;
  assign wdata_unused = ^bus_wdata;

  // trigger fields, one per pin pair
  for (genvar f = 0; f < FLD_N; f++) begin : g_fld
    localparam int WRD = f / FLD_PER_WORD;
    localparam int LSB = (f % FLD_PER_WORD) * NIB_W;

    assign fld_en[f] = wr_act && (bus_addr == ADR_W'(WRD));
    assign fld_d[f]  = bus_wdata[LSB +: FLD_W];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        fld_q[f] <= '0;
      end else if (fld_en[f]) begin
        fld_q[f] <= fld_d[f];
      end
    end
  end

  // mask word
  assign mask_en = wr_act && (bus_addr == RA_MASK);
  assign mask_d  = bus_wdata[PIN_N-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '1;
    end else if (mask_en) begin
      mask_q <= mask_d;
    end
  end

  // pending word: write-one-to-clear, new events take priority
  always_comb begin
    clr_vec = '0;
    if (wr_act && (bus_addr == RA_PEND)) begin
      clr_vec = bus_wdata[PIN_N-1:0];
    end
    pend_d = (pend_q & ~clr_vec) | evt_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
    end else begin
      pend_q <= pend_d;
    end
  end

  // read path
  always_comb begin
    cfg_rd = '0;
    for (int f = 0; f < FLD_N; f++) begin
      cfg_rd[f / FLD_PER_WORD][(f % FLD_PER_WORD) * NIB_W +: FLD_W] = fld_q[f];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      unique case (bus_addr)
        RA_CFG0: bus_rdata = cfg_rd[0];
        RA_CFG1: bus_rdata = cfg_rd[1];
        RA_MASK: bus_rdata = {{PAD_W{1'b0}}, mask_q};
        default: bus_rdata = {{PAD_W{1'b0}}, pend_q};
      endcase
    end
  end

  for (genvar p = 0; p < PIN_N; p++) begin : g_mode
    assign mode_o[p] = fld_q[p / 2];
  end

  assign mask_o = mask_q;
  assign pend_o = pend_q;

endmodule

// File: rtl/xirq_group.sv
module xirq_group
  import xirq_pkg::*;
(
  input  logic [PIN_N-1:0] pend_i,
  input  logic [PIN_N-1:0] mask_i,
  output logic [GRP_N-1:0] req_o
);

  logic [PIN_N-1:0] live;

  assign live = pend_i & ~mask_i;

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    localparam int LO = grp_first(g);
    localparam int HI = grp_last(g);
    assign req_o[g] = |live[HI:LO];
  end

endmodule

// File: rtl/ext_irq_grouper.sv
module ext_irq_grouper
  import xirq_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [PIN_N-1:0]     pin_i,
  input  logic                 bus_sel,
  input  logic                 bus_wr,
  input  logic [ADR_W-1:0]     bus_addr,
  input  logic [DAT_W-1:0]     bus_wdata,
  output logic [DAT_W-1:0]     bus_rdata,
  output logic [GRP_N-1:0]     grp_req_o
);

  logic                        rst_n_q;
  logic [PIN_N-1:0]            lvl_w;
  logic [PIN_N-1:0]            evt_w;
  logic [PIN_N-1:0]            mask_w;
  logic [PIN_N-1:0]            pend_w;
  logic [PIN_N-1:0][FLD_W-1:0] mode_w;

  xirq_rst_sync i_rst_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_o (rst_n_q)
  );

  xirq_sync #(
    .W      (PIN_N),
    .STAGES (2)
  ) i_sync (
    .clk   (clk),
    .rst_n (rst_n_q),
    .d_i   (pin_i),
    .q_o   (lvl_w)
  );

  xirq_detect #(
    .W (PIN_N)
  ) i_detect (
    .clk    (clk),
    .rst_n  (rst_n_q),
    .lvl_i  (lvl_w),
    .mode_i (mode_w),
    .evt_o  (evt_w)
  );

  xirq_regs i_regs (
    .clk       (clk),
    .rst_n     (rst_n_q),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .evt_i     (evt_w),
    .mask_o    (mask_w),
    .pend_o    (pend_w),
    .mode_o    (mode_w)
  );

  xirq_group i_group (
    .pend_i (pend_w),
    .mask_i (mask_w),
    .req_o  (grp_req_o)
  );

endmodule

// File: rtl/xirq_checker.sv
module xirq_checker
  import xirq_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADR_W-1:0]  bus_addr,
  input logic [DAT_W-1:0]  bus_wdata,
  input logic [DAT_W-1:0]  bus_rdata,
  input logic [PIN_N-1:0]  mask_q,
  input logic [PIN_N-1:0]  pend_q,
  input logic [PIN_N-1:0]  evt,
  input logic [GRP_N-1:0]  grp_req
);

  logic             pend_wr;
  logic             mask_wr;
  logic [PIN_N-1:0] clr_seen;

  assign pend_wr  = bus_sel && bus_wr && (bus_addr == RA_PEND);
  assign mask_wr  = bus_sel && bus_wr && (bus_addr == RA_MASK);
  assign clr_seen = pend_wr ? bus_wdata[PIN_N-1:0] : '0;

  AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(pend_q) & ~$past(clr_seen)) & ~pend_q) == '0)); // R8

  AST_PEND_NEEDS_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~$past(evt)) == '0)); // R11

  AST_EVT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pend_q & $past(evt)) == $past(evt))); // R9

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> (grp_req == '0)); // R7

  AST_MASK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !mask_wr |=> $stable(mask_q)); // R7

  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && bus_addr[1]) |-> (bus_rdata[DAT_W-1:PIN_N] == '0)); // R12

endmodule

bind ext_irq_grouper xirq_checker i_xirq_checker (
  .clk       (clk),
  .rst_n     (rst_n_q),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .mask_q    (mask_w),
  .pend_q    (pend_w),
  .evt       (evt_w),
  .grp_req   (grp_req_o)
);

// File: tb/test_ext_irq_grouper.sv
`timescale 1ns/100ps
module test_ext_irq_grouper;

  localparam logic [1:0] A_CFG0 = 2'd0;
  localparam logic [1:0] A_CFG1 = 2'd1;
  localparam logic [1:0] A_MASK = 2'd2;
  localparam logic [1:0] A_PEND = 2'd3;
  localparam logic [2:0] M_LOW  = 3'b000;
  localparam logic [2:0] M_HIGH = 3'b001;
  localparam logic [2:0] M_RISE = 3'b100;
  localparam int         NVEC   = 12;

  // {line[4:0], mode[2:0], start level, final level, expected flag}
  localparam logic [10:0] VEC [NVEC] = '{
    {5'd0,  3'b001, 1'b0, 1'b1, 1'b1},
    {5'd3,  3'b001, 1'b0, 1'b0, 1'b0},
    {5'd5,  3'b000, 1'b1, 1'b0, 1'b1},
    {5'd11, 3'b000, 1'b1, 1'b1, 1'b0},
    {5'd12, 3'b100, 1'b0, 1'b1, 1'b1},
    {5'd16, 3'b101, 1'b1, 1'b0, 1'b0},
    {5'd19, 3'b010, 1'b1, 1'b0, 1'b1},
    {5'd20, 3'b011, 1'b0, 1'b1, 1'b0},
    {5'd27, 3'b110, 1'b0, 1'b1, 1'b1},
    {5'd25, 3'b111, 1'b1, 1'b0, 1'b1},
    {5'd14, 3'b110, 1'b0, 1'b0, 1'b0},
    {5'd22, 3'b100, 1'b0, 1'b1, 1'b1}
  };

  logic        clk;
  logic        rst_n;
  logic [27:0] pins;
  logic        sel;
  logic        wr;
  logic [1:0]  addr;
  logic [31:0] wdata;
  logic [31:0] rdata;
  logic [3:0]  grp;
  logic [31:0] cfg_sh [2];
  logic [31:0] rd;
  int          checks;
  int          errors;
  bit          done;

  ext_irq_grouper i_ext_irq_grouper (
    .clk       (clk),
    .rst_n     (rst_n),
    .pin_i     (pins),
    .bus_sel   (sel),
    .bus_wr    (wr),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .grp_req_o (grp)
  );

  initial begin
    clk = 1'b0;
    forever #2.5 clk = ~clk;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bwrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    sel = 1'b0; wr = 1'b0; wdata = '0;
  endtask

  task automatic bread(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    sel = 1'b1; wr = 1'b0; addr = a;
    #1 d = rdata;
    sel = 1'b0;
  endtask

  task automatic set_mode(input int line, input logic [2:0] m);
    int w;
    int nib;
    w   = line / 16;
    nib = (line % 16) / 2;
    cfg_sh[w][nib*4 +: 4] = {1'b0, m};
    bwrite(w[1:0], cfg_sh[w]);
  endtask

  function automatic int grp_of(input int line);
    if (line < 4)  return 0;
    if (line < 12) return 1;
    if (line < 20) return 2;
    return 3;
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    if (m[2:1] == 2'b00) return "R3 level";
    if (m[2:1] == 2'b01) return "R5 falling";
    if (m[2:1] == 2'b10) return "R4 rising";
    return "R6 both";
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R11 watchdog actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; pins = '0; sel = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    cfg_sh[0] = '0; cfg_sh[1] = '0;
    repeat (3) @(posedge clk);

    // R1 reset state, read while reset is held
    bread(A_MASK, rd); check("R1 mask reset", rd, 32'h0FFF_FFFF);
    bread(A_PEND, rd); check("R1 pending reset", rd, 32'h0);
    bread(A_CFG0, rd); check("R1 cfg0 reset", rd, 32'h0);
    bread(A_CFG1, rd); check("R1 cfg1 reset", rd, 32'h0);
    check("R1 requests reset", {28'h0, grp}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    repeat (4) @(posedge clk);
    check("R1 requests after reset", {28'h0, grp}, 32'h0);

    // R2 field layout and unused bits
    bwrite(A_CFG0, 32'hFFFF_FFFF);
    bread(A_CFG0, rd); check("R2 cfg0 layout", rd, 32'h7777_7777);
    bwrite(A_CFG1, 32'hFFFF_FFFF);
    bread(A_CFG1, rd); check("R2 cfg1 upper fields absent", rd, 32'h0077_7777);
    bwrite(A_CFG0, 32'h0); bwrite(A_CFG1, 32'h0);

    // R12 bits above line 27
    bwrite(A_MASK, 32'hF000_0000);
    bread(A_MASK, rd); check("R12 mask upper write ignored", rd, 32'h0);
    bwrite(A_MASK, 32'hFFFF_FFFF);
    bread(A_MASK, rd); check("R12 mask readback", rd, 32'h0FFF_FFFF);
    bread(A_PEND, rd); check("R12 pending upper zero", rd & 32'hF000_0000, 32'h0);

    // vector table: one trigger scenario per entry
    for (int i = 0; i < NVEC; i++) begin
      automatic int         ln  = int'(VEC[i][10:6]);
      automatic logic [2:0] md  = VEC[i][5:3];
      automatic logic       v0  = VEC[i][2];
      automatic logic       v1  = VEC[i][1];
      automatic logic       exq = VEC[i][0];
      automatic int         g   = grp_of(ln);
      @(negedge clk); pins[ln] = v0;
      set_mode(ln, md);
      repeat (5) @(posedge clk);
      bwrite(A_PEND, 32'hFFFF_FFFF);
      bwrite(A_MASK, ~(32'h1 << ln));
      check("R10 group idle before stimulus", {31'h0, grp[g]}, 32'h0);
      @(negedge clk);
      pins[ln] = v1; sel = 1'b1; wr = 1'b0; addr = A_PEND;
      @(posedge clk); @(posedge clk); @(negedge clk);
      check("R11 flag not before third edge", {31'h0, rdata[ln]}, 32'h0);
      @(posedge clk); @(negedge clk);
      check(tag_of(md), {31'h0, rdata[ln]}, {31'h0, exq});
      check("R10 group request", {31'h0, grp[g]}, {31'h0, exq});
      sel = 1'b0;
      bwrite(A_MASK, 32'hFFFF_FFFF);
    end

    // R9 event and clear in the same cycle, then R8 clear semantics
    @(negedge clk); pins[9] = 1'b0;
    set_mode(9, M_RISE);
    repeat (5) @(posedge clk);
    bwrite(A_PEND, 32'hFFFF_FFFF);
    @(negedge clk); pins[9] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); sel = 1'b1; wr = 1'b1; addr = A_PEND; wdata = 32'h1 << 9;
    @(negedge clk); sel = 1'b0; wr = 1'b0; wdata = '0;
    bread(A_PEND, rd); check("R9 set wins over clear", {31'h0, rd[9]}, 32'h1);
    bwrite(A_PEND, 32'h0);
    bread(A_PEND, rd); check("R8 zero write keeps flag", {31'h0, rd[9]}, 32'h1);
    bwrite(A_PEND, 32'h1 << 9);
    bread(A_PEND, rd); check("R8 one write clears flag", {31'h0, rd[9]}, 32'h0);

    // R7 masked line still latches, request stays low
    @(negedge clk); pins[13] = 1'b0;
    set_mode(13, M_RISE);
    repeat (5) @(posedge clk);
    bwrite(A_PEND, 32'hFFFF_FFFF);
    @(negedge clk); pins[13] = 1'b1;
    repeat (4) @(posedge clk);
    bread(A_PEND, rd); check("R7 pending while masked", {31'h0, rd[13]}, 32'h1);
    check("R7 masked request low", {31'h0, grp[2]}, 32'h0);

    // R3 level held active defeats the clear
    @(negedge clk); pins[21] = 1'b1;
    set_mode(21, M_HIGH);
    repeat (4) @(posedge clk);
    bwrite(A_PEND, 32'h1 << 21);
    bread(A_PEND, rd); check("R3 clear while level active", {31'h0, rd[21]}, 32'h1);
    @(negedge clk); pins[21] = 1'b0;
    repeat (4) @(posedge clk);
    bwrite(A_PEND, 32'h1 << 21);
    bread(A_PEND, rd); check("R3 clear after level gone", {31'h0, rd[21]}, 32'h0);

    // R13 field configured through line 6 governs line 7
    @(negedge clk); pins[7] = 1'b0; pins[6] = 1'b0;
    set_mode(6, M_RISE);
    repeat (5) @(posedge clk);
    bwrite(A_PEND, 32'hFFFF_FFFF);
    @(negedge clk); pins[7] = 1'b1;
    repeat (4) @(posedge clk);
    bread(A_PEND, rd); check("R13 partner line follows field", {31'h0, rd[7]}, 32'h1);
    check("R13 line 6 untouched", {31'h0, rd[6]}, 32'h0);

    // R10 OR of several lines in one group
    @(negedge clk); pins[4] = 1'b0; pins[11] = 1'b0;
    set_mode(4, M_RISE);
    set_mode(11, M_RISE);
    repeat (5) @(posedge clk);
    bwrite(A_PEND, 32'hFFFF_FFFF);
    bwrite(A_MASK, ~((32'h1 << 4) | (32'h1 << 11)));
    @(negedge clk); pins[4] = 1'b1; pins[11] = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check("R10 two lines raise group 1", {28'h0, grp}, 32'h2);
    bwrite(A_PEND, 32'h1 << 4);
    check("R10 one line keeps group 1", {28'h0, grp}, 32'h2);
    bwrite(A_PEND, 32'h1 << 11);
    check("R10 group 1 drops", {28'h0, grp}, 32'h0);
    bwrite(A_MASK, 32'hFFFF_FFFF);
    set_mode(4, M_LOW);

    done = 1'b1;
    summary();
    $finish;
  end

endmodule